// File: doc/BRIEF.md
# Receive FIFO with Hysteresis Flow Control

This block is the receive-side byte queue of one serial channel. Bytes arrive from the deserializer through a write strobe and leave through a host read strobe. The queue holds up to 64 bytes and reports its fill level on an 8-bit port. A programmable trigger level drives a level-sensitive interrupt.

Flow control drives one of two active-low modem request outputs. A select bit picks the request-to-send or the data-terminal-ready pin. In automatic mode the selected pin rises once the fill level reaches an upper threshold, the trigger plus the hysteresis. It falls again only after the level drops below a lower threshold, the trigger minus the hysteresis. Between the two thresholds the pin keeps its state.

Automatic control only acts while software holds the selected pin's output bit active. With automatic mode off, both pins follow their software bits.

Top module: `rxq_top`

## Requirements
- R1: After reset the level is 0, the overflow flag is 0, and the flow state is released, so each pin equals the inverse of its software bit.
- R2: An accepted write raises the level by one and an accepted read lowers it by one. A write and a read in the same cycle leave the level unchanged. Bytes leave in arrival order, and `rd_data` shows the byte on the clock edge that accepts the read.
- R3: A write while the level is 64 and no read is requested is dropped, and `ovf` goes to 1 and stays at 1 until reset. A write together with a read at level 64 is accepted.
- R4: A read at level 0 leaves the level at 0 and `rd_data` unchanged. A write together with a read at level 0 stores the byte and leaves `rd_data` unchanged.
- R5: `irq` is 1 exactly while the level is at or above the effective trigger.
- R6: With `auto_en`=1 and the selected pin's software bit at 1, the selected pin goes to 1 one clock after the level reaches min(trigger+hysteresis, 64).
- R7: The pin from R6 returns to 0 one clock after the level falls below max(trigger−hysteresis, 0). At levels between the two thresholds it keeps its previous value.
- R8: With `auto_en`=1 and the selected pin's software bit at 0, the selected pin is 1 at any level.
- R9: `pin_sel`=0 applies the automatic behaviour to `rts_n`, and `pin_sel`=1 applies it to `dtr_n`. The unselected pin always equals the inverse of its software bit.
- R10: With `auto_en`=0 each pin equals the inverse of its software bit at any level.
- R11: A trigger value above 64 acts as 64, so with trigger 200 `irq` is 0 at level 63 and 1 at level 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe from the deserializer |
| wr_data | input | 8 | Byte to store |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Last byte read |
| level | output | 8 | Number of bytes held, 0 to 64 |
| trig_lvl | input | 8 | Interrupt trigger level |
| hyst | input | 8 | Hysteresis distance around the trigger |
| auto_en | input | 1 | 1 enables automatic flow control |
| pin_sel | input | 1 | 0 selects `rts_n`, 1 selects `dtr_n` |
| sw_rts | input | 1 | Software bit for `rts_n`, 1 means drive the pin low |
| sw_dtr | input | 1 | Software bit for `dtr_n`, 1 means drive the pin low |
| irq | output | 1 | Level interrupt |
| ovf | output | 1 | Sticky overflow flag |
| rts_n | output | 1 | Active-low request-to-send |
| dtr_n | output | 1 | Active-low data-terminal-ready |

## Verification
A read and a write can land in the same cycle, and this matters most at the two boundaries. At level 64 the pair must be accepted, with no overflow. At level 0 the read must be ignored while the write still lands. The bench fills the queue to 64 and raises both strobes in one cycle, then does the same from empty. It judges each case by the next level, the `rd_data` value against a queue model, and `ovf`.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
   typedef enum logic {
      FLOW_GO   = 1'b0,
      FLOW_STOP = 1'b1
   } flow_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic              ovf
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              rd_ok, wr_ok;

   function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   // a read needs data; a write needs room, or a read freeing a slot
   assign rd_ok = rd_en && (count != '0);
   assign wr_ok = wr_en && ((count != CNT_W'(DEPTH)) || rd_ok);

   always_ff @(posedge clk) begin
      if (wr_ok) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         rd_data <= '0;
         ovf     <= 1'b0;
      end else begin
         if (wr_ok) wr_ptr <= ptr_next(wr_ptr);
         if (rd_ok) begin
            rd_ptr  <= ptr_next(rd_ptr);
            rd_data <= mem[rd_ptr];
         end
         case ({wr_ok, rd_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
         if (wr_en && !wr_ok) ovf <= 1'b1;
      end
   end

   a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));
   a_r3_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH) && wr_en && !rd_en) |=> (count == CNT_W'(DEPTH) && ovf));
   a_r3_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> ovf);
   a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (count == '0 && rd_en && !wr_en) |=> (count == '0 && $stable(rd_data)));
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
   parameter int DEPTH = 64,
   parameter int LVL_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [LVL_W-1:0] trig_lvl,
   output logic [CNT_W-1:0] trig_c,
   output logic             irq
);
   // trigger values above the depth act as the depth
   assign trig_c = (trig_lvl > LVL_W'(DEPTH)) ? CNT_W'(DEPTH) : trig_lvl[CNT_W-1:0];
   assign irq    = (count >= trig_c);

   a_r11_trig_clamped: assert property (@(posedge clk) disable iff (!rst_n)
      trig_c <= CNT_W'(DEPTH));
   a_r5_irq_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_W'(DEPTH)) |-> irq);
endmodule

// File: rtl/rxq_flow.sv
module rxq_flow
   import rxq_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int LVL_W = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count,
   input  logic [CNT_W-1:0] trig_c,
   input  logic [LVL_W-1:0] hyst,
   input  logic             auto_en,
   input  logic             pin_sel,
   input  logic             sw_rts,
   input  logic             sw_dtr,
   output logic             rts_n,
   output logic             dtr_n
);
   flow_state_e      state;
   logic [LVL_W:0]   up_sum;
   logic [LVL_W-1:0] lo_diff;
   logic [CNT_W-1:0] upper, lower;
   logic [1:0]       sw_bits, pin_n;

   assign up_sum  = {1'b0, LVL_W'(trig_c)} + {1'b0, hyst};
   assign upper   = (up_sum > (LVL_W + 1)'(DEPTH)) ? CNT_W'(DEPTH) : up_sum[CNT_W-1:0];
   assign lo_diff = (LVL_W'(trig_c) > hyst) ? (LVL_W'(trig_c) - hyst) : '0;
   assign lower   = lo_diff[CNT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= FLOW_GO;
      end else if (!auto_en) begin
         state <= FLOW_GO;
      end else if (count >= upper) begin
         state <= FLOW_STOP;
      end else if (count < lower) begin
         state <= FLOW_GO;
      end
   end

   assign sw_bits = {sw_dtr, sw_rts};

   for (genvar g = 0; g < 2; g++) begin : g_pin
      always_comb begin
         if (auto_en && (pin_sel == g[0]))
            pin_n[g] = !sw_bits[g] || (state == FLOW_STOP);
         else
            pin_n[g] = !sw_bits[g];
      end
   end

   assign rts_n = pin_n[0];
   assign dtr_n = pin_n[1];

   a_r6_stop_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && count >= upper) |=> (state == FLOW_STOP || !auto_en));
   a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en && count < upper && count >= lower) |=> (state == $past(state) || !auto_en));
   a_r9_unsel_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_sel == 1'b0) |-> (dtr_n == !sw_dtr));
   a_r10_manual: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_en |-> (rts_n == !sw_rts && dtr_n == !sw_dtr));
endmodule

// File: rtl/rxq_top.sv
module rxq_top #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 64,
   parameter int LVL_W  = 8,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic [LVL_W-1:0]  level,
   input  logic [LVL_W-1:0]  trig_lvl,
   input  logic [LVL_W-1:0]  hyst,
   input  logic              auto_en,
   input  logic              pin_sel,
   input  logic              sw_rts,
   input  logic              sw_dtr,
   output logic              irq,
   output logic              ovf,
   output logic              rts_n,
   output logic              dtr_n
);
   logic [CNT_W-1:0] count, trig_c;

   if (DEPTH < 2) begin : g_bad_depth
      $error("rxq_top: DEPTH must be at least 2");
   end
   if (LVL_W < CNT_W) begin : g_bad_lvl
      $error("rxq_top: LVL_W too narrow for DEPTH");
   end

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .count(count), .ovf(ovf)
   );

   rxq_trig #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_trig (
      .clk(clk), .rst_n(rst_n), .count(count), .trig_lvl(trig_lvl),
      .trig_c(trig_c), .irq(irq)
   );

   rxq_flow #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flow (
      .clk(clk), .rst_n(rst_n), .count(count), .trig_c(trig_c), .hyst(hyst),
      .auto_en(auto_en), .pin_sel(pin_sel), .sw_rts(sw_rts), .sw_dtr(sw_dtr),
      .rts_n(rts_n), .dtr_n(dtr_n)
   );

   assign level = LVL_W'(count);
endmodule

// File: tb/sim_rxq_top.sv
`timescale 1ns/1ps
module sim_rxq_top;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       wr_en = 0, rd_en = 0, auto_en = 0, pin_sel = 0, sw_rts = 0, sw_dtr = 0;
   logic [7:0] wr_data = 0, trig_lvl = 8'd4, hyst = 0;
   logic [7:0] rd_data, level;
   logic       irq, ovf, rts_n, dtr_n;
   int         n_chk = 0, n_fail = 0;
   logic [7:0] exp_q[$];
   logic [7:0] last_rd = 0;
   logic [7:0] seed = 8'h11;
   bit         done = 0;

   always #10 clk = ~clk;

   rxq_top u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
      .rd_data(rd_data), .level(level), .trig_lvl(trig_lvl), .hyst(hyst), .auto_en(auto_en),
      .pin_sel(pin_sel), .sw_rts(sw_rts), .sw_dtr(sw_dtr), .irq(irq), .ovf(ovf),
      .rts_n(rts_n), .dtr_n(dtr_n));

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // one cycle with the given strobes; model updated per R2-R4
   task automatic cyc(input logic w, input logic r);
      logic popped;
      @(negedge clk);
      wr_en = w; rd_en = r; wr_data = seed;
      popped = 0;
      if (r && exp_q.size() > 0) begin last_rd = exp_q.pop_front(); popped = 1; end
      if (w && (exp_q.size() < 64 || popped)) exp_q.push_back(seed);
      seed = seed * 8'd5 + 8'd3;
      @(negedge clk);
      wr_en = 0; rd_en = 0;
      chk("R2 level", level, 8'(exp_q.size()));
      chk("R2 rd_data", rd_data, last_rd);
   endtask

   task automatic fill_to(input int n);
      while (exp_q.size() < n) cyc(1, 0);
   endtask
   task automatic drain_to(input int n);
      while (exp_q.size() > n) cyc(0, 1);
   endtask
   task automatic settle();
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 level", level, 0);
      chk("R1 ovf", {7'd0, ovf}, 0);
      chk("R1 rts_n", {7'd0, rts_n}, 1);
      chk("R1 dtr_n", {7'd0, dtr_n}, 1);
      chk("R5 irq reset", {7'd0, irq}, 0);
   endtask

   task automatic t_order();
      fill_to(3);
      chk("R2 three held", level, 3);
      drain_to(0);
      fill_to(1);
      cyc(1, 1);
      chk("R2 simultaneous keeps level", level, 1);
      drain_to(0);
   endtask

   task automatic t_irq();
      trig_lvl = 8'd4;
      fill_to(3);
      chk("R5 below trigger", {7'd0, irq}, 0);
      fill_to(4);
      chk("R5 at trigger", {7'd0, irq}, 1);
      drain_to(3);
      chk("R5 falls below", {7'd0, irq}, 0);
      drain_to(0);
   endtask

   task automatic t_full();
      trig_lvl = 8'd200;
      fill_to(63);
      chk("R11 clamp at 63", {7'd0, irq}, 0);
      fill_to(64);
      chk("R11 clamp at 64", {7'd0, irq}, 1);
      chk("R3 no ovf yet", {7'd0, ovf}, 0);
      cyc(1, 0);
      chk("R3 full drop level", level, 64);
      chk("R3 ovf set", {7'd0, ovf}, 1);
      cyc(1, 1);
      chk("R3 full rd+wr level", level, 64);
      drain_to(0);
      chk("R3 ovf sticky", {7'd0, ovf}, 1);
   endtask

   task automatic t_empty();
      logic [7:0] held;
      held = rd_data;
      cyc(0, 1);
      chk("R4 empty read level", level, 0);
      chk("R4 empty read data", rd_data, held);
      cyc(1, 1);
      chk("R4 empty rd+wr level", level, 1);
      chk("R4 empty rd+wr data", rd_data, held);
      drain_to(0);
   endtask

   task automatic t_hyst();
      trig_lvl = 8'd8; hyst = 8'd2; auto_en = 1; pin_sel = 0; sw_rts = 1;
      fill_to(9); settle();
      chk("R6 below upper", {7'd0, rts_n}, 0);
      fill_to(10); settle();
      chk("R6 at upper", {7'd0, rts_n}, 1);
      drain_to(7); settle();
      chk("R7 hold between", {7'd0, rts_n}, 1);
      drain_to(6); settle();
      chk("R7 at lower holds", {7'd0, rts_n}, 1);
      drain_to(5); settle();
      chk("R7 below lower", {7'd0, rts_n}, 0);
      fill_to(9); settle();
      chk("R7 hold rising", {7'd0, rts_n}, 0);
   endtask

   task automatic t_inactive();
      sw_rts = 0; settle();
      chk("R8 sw inactive", {7'd0, rts_n}, 1);
   endtask

   task automatic t_select();
      sw_rts = 1; sw_dtr = 1; pin_sel = 1;
      fill_to(10); settle();
      chk("R9 dtr stops", {7'd0, dtr_n}, 1);
      chk("R9 rts unselected", {7'd0, rts_n}, 0);
   endtask

   task automatic t_manual();
      auto_en = 0; settle();
      chk("R10 manual dtr", {7'd0, dtr_n}, 0);
      sw_dtr = 0; settle();
      chk("R10 manual dtr off", {7'd0, dtr_n}, 1);
      chk("R10 manual rts", {7'd0, rts_n}, 0);
      drain_to(0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_order();
      t_irq();
      t_full();
      t_empty();
      t_hyst();
      t_inactive();
      t_select();
      t_manual();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule